// File: doc/BRIEF.md
# Removable Flash Card Host Pin Decoder

This block sits on the card side of a removable flash storage card. It reads the host's address, two active-low byte enables, the memory and I/O strobes and the attribute-select line, and works out three things: which internal storage space is addressed, which byte lanes of the 16-bit data bus carry data, and what the two shared status pins mean right now. The storage spaces are modelled as small arrays. These are an attribute byte space that exists at even addresses only, a common memory byte array, an eight-entry task-file register bank with a 16-bit data port, and a device-control byte.

The card has three personalities. Memory mode is the default. The host moves the card into I/O mode by writing a nonzero value to a configuration byte in attribute space, and writing zero moves it back. If the output-enable input is held low while reset is released, the card takes the disk-style personality for the whole reset period. In that personality only the low three address bits matter, the second enable selects the control pair, and the write-enable and attribute-select inputs have no effect. After each reset a fixed busy window runs. During it the card ignores every access.

Top module: `fcard_bus_decode`

## Requirements
- R1: The personality is captured from output-enable on the last reset cycle: low gives disk-style mode. After reset a change on output-enable leaves the personality unchanged.
- R2: For INIT_CYCLES clocks after reset release the card is busy. Writes are dropped, the bus is not driven, and in memory mode the ready pin `rdy_irq` is 0. When busy ends the ready pin goes to 1.
- R3: Common memory, in memory mode with `reg_n`=1: enable 1 alone moves the byte at the full address (bit 0 included) on D[7:0]. Enable 2 alone moves the byte at address|1 on D[15:8]. Both enables give a word in which address bit 0 is ignored, with the even byte on D[7:0] and the odd byte on D[15:8]. With neither enable low, `dq_oe`=0. Unused lanes read as 0.
- R4: Attribute space (`reg_n`=0) holds bytes at even addresses only. A word read returns 0x00 on D[15:8]. An odd-address byte access reads 0x00 with the bus driven, and an odd write changes nothing.
- R5: Writing a nonzero byte to attribute address 0x200 selects I/O mode. Writing 0x00 there returns the card to memory mode, where the ready pin reads 1 and the I/O strobes have no effect again.
- R6: In memory mode the I/O read strobe does not drive the bus, and the I/O write strobe stores nothing.
- R7: In I/O mode the I/O strobes access the task file at address bits 2:0, and higher bits are ignored. Lanes follow the R3 rules. A word at index 0 is the 16-bit data port. Otherwise the even lane holds register n and the odd lane holds register n|1, and a byte access to index 0 gives the data port's low byte. `wp_io16` is 0 during a word I/O access and 1 during a byte one.
- R8: The `rdy_irq` pin depends on the personality. In memory mode it is ready. In I/O mode it is `media_irq` inverted. In disk-style mode it is `media_irq` gated by the interrupt-disable bit.
- R9: In disk-style mode `iord_n`/`iowr_n` with enable 1 alone access task register `host_addr[2:0]`, and the higher address bits, `we_n` and `reg_n` have no effect.
- R10: In disk-style mode, enable 2 alone reads task register 7 as alternate status and writes the device-control byte. A 1 in bit 1 of that byte forces `rdy_irq` to 0.
- R11: In disk-style mode, enable 1 alone at index 0 selects a 16-bit data transfer on D[15:0] and drives `wp_io16` to 0. At other indices `wp_io16` is 1 and data is on D[7:0] only.
- R12: In memory mode `wp_io16` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Host address |
| ce1_n | input | 1 | Even-byte enable, active low |
| ce2_n | input | 1 | Odd-byte enable, active low |
| oe_n | input | 1 | Memory read strobe and personality select |
| we_n | input | 1 | Memory write strobe |
| iord_n | input | 1 | I/O read strobe |
| iowr_n | input | 1 | I/O write strobe |
| reg_n | input | 1 | Low selects attribute space |
| dq_in | input | 16 | Write data from host |
| dq_out | output | 16 | Read data to host |
| dq_oe | output | 1 | High while the card drives the data bus |
| media_irq | input | 1 | Interrupt request from the media controller, active high |
| rdy_irq | output | 1 | Ready, or interrupt request, depending on personality |
| wp_io16 | output | 1 | Write-protect, or 16-bit indication, depending on personality |

## Verification
A wrongly captured personality changes the meaning of every pin. It shows at once as a misread strobe, an inverted `rdy_irq` or a wrong `wp_io16` on the first access. A busy counter that ends early or late shows as a write that is kept or lost, or as the ready pin changing state at the wrong time. Lane-steering or index faults appear in the same cycle as a swapped or zeroed byte in `dq_out`. A configuration byte stored in the wrong place, or at the wrong address, first shows when an I/O strobe drives the bus in memory mode or fails to drive it in I/O mode.

// File: rtl/fcb_pkg.sv
package fcb_pkg;

   typedef enum logic [1:0] {
      MODE_MEM = 2'd0,
      MODE_IO  = 2'd1,
      MODE_IDE = 2'd2
   } fcb_mode_e;

   typedef enum logic [2:0] {
      SP_NONE   = 3'd0,
      SP_ATTR   = 3'd1,
      SP_COMMON = 3'd2,
      SP_TASK   = 3'd3,
      SP_CTRL   = 3'd4
   } fcb_space_e;

   typedef struct packed {
      logic lo_en;   // even lane D[7:0] active
      logic hi_en;   // odd lane D[15:8] active
      logic word;    // both lanes as one 16-bit transfer
      logic alt;     // control pair selected (disk-style mode)
   } fcb_lane_t;

endpackage

// File: rtl/fcb_mode_ctrl.sv
module fcb_mode_ctrl #(
   parameter int INIT_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_n,
   output logic ide_q,
   output logic busy
);
   localparam int CW = $clog2(INIT_CYCLES + 1);
   localparam logic [CW-1:0] INIT_V = CW'(INIT_CYCLES);

   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ide_q <= !oe_n;
         cnt_q <= '0;
      end else if (cnt_q != INIT_V) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign busy = (cnt_q != INIT_V);

endmodule

// File: rtl/fcb_lane_steer.sv
module fcb_lane_steer
   import fcb_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              ide,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce1_n,
   input  logic              ce2_n,
   output fcb_lane_t         lane,
   output logic [ADDR_W-1:0] lo_idx,
   output logic [ADDR_W-1:0] hi_idx
);
   if (ADDR_W < 4) begin : g_bad_aw
      $error("ADDR_W must be at least 4");
   end

   always_comb begin
      lane   = '0;
      lo_idx = addr;
      hi_idx = {addr[ADDR_W-1:1], 1'b1};
      if (ide) begin
         lo_idx = {{(ADDR_W-3){1'b0}}, addr[2:0]};
         hi_idx = {{(ADDR_W-3){1'b0}}, addr[2:1], 1'b1};
         if (!ce1_n && ce2_n) begin
            lane.lo_en = 1'b1;
            if (addr[2:0] == 3'd0) begin
               lane.hi_en = 1'b1;
               lane.word  = 1'b1;
            end
         end else if (ce1_n && !ce2_n) begin
            lane.lo_en = 1'b1;
            lane.alt   = 1'b1;
         end
      end else begin
         case ({ce2_n, ce1_n})
            2'b10: lane.lo_en = 1'b1;
            2'b01: lane.hi_en = 1'b1;
            2'b00: begin
               lane.lo_en = 1'b1;
               lane.hi_en = 1'b1;
               lane.word  = 1'b1;
               lo_idx     = {addr[ADDR_W-1:1], 1'b0};
            end
            default: lane = '0;
         endcase
      end
   end

endmodule

// File: rtl/fcb_store.sv
module fcb_store
   import fcb_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int ATTR_DEPTH   = 16,
   parameter int COMMON_DEPTH = 64,
   parameter int CFG_ADDR     = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fcb_space_e        space,
   input  logic              wr_en,
   input  fcb_lane_t         lane,
   input  logic [ADDR_W-1:0] lo_idx,
   input  logic [ADDR_W-1:0] hi_idx,
   input  logic [15:0]       wdata,
   output logic [15:0]       rdata,
   output logic              io_en,
   output logic              nien
);
   localparam int AIW = $clog2(ATTR_DEPTH);
   localparam int CIW = $clog2(COMMON_DEPTH);
   localparam logic [ADDR_W-1:0] CFG_V  = ADDR_W'(CFG_ADDR);
   localparam logic [ADDR_W-1:0] ATTR_LIM = ADDR_W'(2 * ATTR_DEPTH);

   if ((ATTR_DEPTH < 2) || ((1 << AIW) != ATTR_DEPTH)) begin : g_bad_attr
      $error("ATTR_DEPTH must be a power of two, at least 2");
   end
   if ((COMMON_DEPTH < 2) || ((1 << CIW) != COMMON_DEPTH)) begin : g_bad_common
      $error("COMMON_DEPTH must be a power of two, at least 2");
   end
   if ((CFG_ADDR % 2 != 0) || (CFG_ADDR < 2 * ATTR_DEPTH) || (CFG_ADDR >= (1 << ADDR_W))) begin : g_bad_cfg
      $error("CFG_ADDR must be even, above the attribute array and inside the address range");
   end

   logic [7:0]  attr_q [ATTR_DEPTH];
   logic [7:0]  cmem_q [COMMON_DEPTH];
   logic [7:0]  tf_q   [8];
   logic [15:0] tf_data_q;
   logic [7:0]  cfg_q;
   logic [7:0]  ctl_q;

   logic [7:0] lo_hit, hi_hit;
   for (genvar g = 0; g < 8; g++) begin : g_tf_hit
      assign lo_hit[g] = (lo_idx[2:0] == 3'(g));
      assign hi_hit[g] = (hi_idx[2:0] == 3'(g));
   end

   logic attr_lo_ok;
   assign attr_lo_ok = !lo_idx[0] && (lo_idx < ATTR_LIM);
   logic data_word;
   assign data_word = lane.word && lo_hit[0];

   function automatic logic [7:0] attr_rd(input logic [ADDR_W-1:0] i);
      if (i[0])                 return 8'h00;
      else if (i == CFG_V)      return cfg_q;
      else if (i < ATTR_LIM)    return attr_q[i[AIW:1]];
      else                      return 8'h00;
   endfunction

   function automatic logic [7:0] tf_rd(input logic [ADDR_W-1:0] i);
      if (i[2:0] == 3'd0) return tf_data_q[7:0];
      else                return tf_q[i[2:0]];
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < ATTR_DEPTH; k++)   attr_q[k] <= '0;
         for (int k = 0; k < COMMON_DEPTH; k++) cmem_q[k] <= '0;
         for (int k = 0; k < 8; k++)            tf_q[k]   <= '0;
         tf_data_q <= '0;
         cfg_q     <= '0;
         ctl_q     <= '0;
      end else if (wr_en) begin
         case (space)
            SP_ATTR: begin
               if (lane.lo_en && !lo_idx[0]) begin
                  if (lo_idx == CFG_V)  cfg_q <= wdata[7:0];
                  else if (attr_lo_ok)  attr_q[lo_idx[AIW:1]] <= wdata[7:0];
               end
            end
            SP_COMMON: begin
               if (lane.lo_en) cmem_q[lo_idx[CIW-1:0]] <= wdata[7:0];
               if (lane.hi_en) cmem_q[hi_idx[CIW-1:0]] <= wdata[15:8];
            end
            SP_TASK: begin
               for (int k = 0; k < 8; k++) begin
                  if (lane.lo_en && lo_hit[k]) begin
                     if (k == 0) tf_data_q[7:0] <= wdata[7:0];
                     else        tf_q[k]        <= wdata[7:0];
                  end
                  if (lane.hi_en && !data_word && hi_hit[k] && (k != 0))
                     tf_q[k] <= wdata[15:8];
               end
               if (lane.hi_en && data_word) tf_data_q[15:8] <= wdata[15:8];
            end
            SP_CTRL: ctl_q <= wdata[7:0];
            default: ;
         endcase
      end
   end

   logic [7:0] lo_b, hi_b;
   always_comb begin
      lo_b = 8'h00;
      hi_b = 8'h00;
      case (space)
         SP_ATTR: begin
            lo_b = attr_rd(lo_idx);
            hi_b = attr_rd(hi_idx);
         end
         SP_COMMON: begin
            lo_b = cmem_q[lo_idx[CIW-1:0]];
            hi_b = cmem_q[hi_idx[CIW-1:0]];
         end
         SP_TASK: begin
            lo_b = tf_rd(lo_idx);
            hi_b = data_word ? tf_data_q[15:8] : tf_rd(hi_idx);
         end
         SP_CTRL: lo_b = tf_q[7];
         default: ;
      endcase
   end

   assign rdata = {lane.hi_en ? hi_b : 8'h00, lane.lo_en ? lo_b : 8'h00};
   assign io_en = (cfg_q != 8'h00);
   assign nien  = ctl_q[1];

endmodule

// File: rtl/fcard_bus_decode.sv
module fcard_bus_decode
   import fcb_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int ATTR_DEPTH   = 16,
   parameter int COMMON_DEPTH = 64,
   parameter int CFG_ADDR     = 512,
   parameter int INIT_CYCLES  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              ce1_n,
   input  logic              ce2_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              iord_n,
   input  logic              iowr_n,
   input  logic              reg_n,
   input  logic [15:0]       dq_in,
   output logic [15:0]       dq_out,
   output logic              dq_oe,
   input  logic              media_irq,
   output logic              rdy_irq,
   output logic              wp_io16
);
   logic              ide_q, busy, io_en, nien;
   fcb_lane_t         lane;
   logic [ADDR_W-1:0] lo_idx, hi_idx;
   fcb_mode_e         mode;
   fcb_space_e        space;
   logic              rd, wr, act;
   logic [15:0]       rdata;

   fcb_mode_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_mode (
      .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ide_q(ide_q), .busy(busy)
   );

   fcb_lane_steer #(.ADDR_W(ADDR_W)) u_lane (
      .ide(ide_q), .addr(host_addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
      .lane(lane), .lo_idx(lo_idx), .hi_idx(hi_idx)
   );

   fcb_store #(
      .ADDR_W(ADDR_W), .ATTR_DEPTH(ATTR_DEPTH),
      .COMMON_DEPTH(COMMON_DEPTH), .CFG_ADDR(CFG_ADDR)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .space(space), .wr_en(act && wr),
      .lane(lane), .lo_idx(lo_idx), .hi_idx(hi_idx), .wdata(dq_in),
      .rdata(rdata), .io_en(io_en), .nien(nien)
   );

   assign mode = ide_q ? MODE_IDE : (io_en ? MODE_IO : MODE_MEM);

   always_comb begin
      space = SP_NONE;
      rd    = 1'b0;
      wr    = 1'b0;
      if (mode == MODE_IDE) begin
         rd    = !iord_n;
         wr    = !iowr_n;
         space = lane.alt ? SP_CTRL : SP_TASK;
      end else if ((mode == MODE_IO) && (!iord_n || !iowr_n)) begin
         rd    = !iord_n;
         wr    = !iowr_n;
         space = SP_TASK;
      end else if (!oe_n || !we_n) begin
         rd    = !oe_n;
         wr    = !we_n;
         space = reg_n ? SP_COMMON : SP_ATTR;
      end
   end

   assign act    = !busy && (lane.lo_en || lane.hi_en) && (space != SP_NONE);
   assign dq_oe  = act && rd;
   assign dq_out = dq_oe ? rdata : 16'h0000;

   always_comb begin
      case (mode)
         MODE_IO: begin
            rdy_irq = !media_irq;
            wp_io16 = !(act && (space == SP_TASK) && lane.word);
         end
         MODE_IDE: begin
            rdy_irq = media_irq && !nien && !busy;
            wp_io16 = !(lane.word && !busy);
         end
         default: begin
            rdy_irq = !busy;
            wp_io16 = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/fcb_checker.sv
module fcb_checker
   import fcb_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        ce1_n,
   input logic        ce2_n,
   input logic        oe_n,
   input logic        iord_n,
   input logic        reg_n,
   input logic        dq_oe,
   input logic [15:0] dq_out,
   input logic        wp_io16,
   input fcb_mode_e   mode,
   input logic        busy,
   input logic        ide_q
);
   // R1
   a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(ide_q));

   // R2
   a_r2_busy_once: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !busy);

   // R2
   a_r2_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !dq_oe);

   // R3
   a_r3_idle_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      (ce1_n && ce2_n) |-> !dq_oe);

   // R4
   a_r4_attr_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode != MODE_IDE) && dq_oe && !oe_n && !reg_n && iord_n) |-> (dq_out[15:8] == 8'h00));

   // R6
   a_r6_io_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_MEM) && oe_n && !iord_n) |-> !dq_oe);

   // R12
   a_r12_wp_low_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_MEM) |-> !wp_io16);

endmodule

bind fcard_bus_decode fcb_checker u_fcb_checker (
   .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n),
   .iord_n(iord_n), .reg_n(reg_n), .dq_oe(dq_oe), .dq_out(dq_out),
   .wp_io16(wp_io16), .mode(mode), .busy(busy), .ide_q(ide_q)
);

// File: tb/fcard_bus_decode_tb_top.sv
`timescale 1ns/100ps
module fcard_bus_decode_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] host_addr = '0;
   logic        ce1_n = 1'b1, ce2_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic        iord_n = 1'b1, iowr_n = 1'b1, reg_n = 1'b1;
   logic [15:0] dq_in = '0;
   logic [15:0] dq_out;
   logic        dq_oe;
   logic        media_irq = 1'b0;
   logic        rdy_irq, wp_io16;

   always #2.5 clk = ~clk;

   fcard_bus_decode dut_i (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
      .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n), .reg_n(reg_n),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .media_irq(media_irq),
      .rdy_irq(rdy_irq), .wp_io16(wp_io16)
   );

   typedef struct {
      string       tag;
      logic [15:0] d;
      logic        oe;
   } exp_t;

   exp_t q[$];
   event mon_ev;
   int   n_run = 0, n_fail = 0;
   bit   finished = 0;
   logic idle_oe = 1'b1;
   logic noise = 1'b0;

   // monitor: pops expected items and compares against the bus
   always begin
      exp_t e;
      @(mon_ev);
      while (q.size() > 0) begin
         e = q.pop_front();
         n_run++;
         if ((dq_oe !== e.oe) || (e.oe && (dq_out !== e.d))) begin
            n_fail++;
            $display("FAIL %s: got oe=%0b d=%h expected oe=%0b d=%h",
                     e.tag, dq_oe, dq_out, e.oe, e.d);
         end
      end
   end

   task automatic chk(input string tag, input logic got, input logic exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic go_idle();
      ce1_n  = 1'b1;
      ce2_n  = 1'b1;
      oe_n   = idle_oe;
      we_n   = noise ? 1'b0 : 1'b1;
      reg_n  = noise ? 1'b0 : 1'b1;
      iord_n = 1'b1;
      iowr_n = 1'b1;
   endtask

   task automatic acc_wr(input bit io, input bit attr, input logic c1, input logic c2,
                         input logic [10:0] a, input logic [15:0] d);
      @(negedge clk);
      ce1_n = c1; ce2_n = c2; host_addr = a; dq_in = d;
      if (attr) reg_n = 1'b0;
      if (io) iowr_n = 1'b0; else we_n = 1'b0;
      @(negedge clk);
      go_idle();
   endtask

   task automatic acc_rd(input string tag, input bit io, input bit attr,
                         input logic c1, input logic c2, input logic [10:0] a,
                         input logic [15:0] exp_d, input logic exp_oe,
                         input bit chk_wp, input logic exp_wp);
      exp_t e;
      @(negedge clk);
      ce1_n = c1; ce2_n = c2; host_addr = a;
      if (attr) reg_n = 1'b0;
      if (io) iord_n = 1'b0; else oe_n = 1'b0;
      @(posedge clk);
      #1;
      e.tag = tag; e.d = exp_d; e.oe = exp_oe;
      q.push_back(e);
      ->mon_ev;
      if (chk_wp) chk({tag, " wp_io16"}, wp_io16, exp_wp);
      @(negedge clk);
      go_idle();
   endtask

   task automatic settle();
      @(posedge clk);
      #1;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      // ---------------- memory-card personality ----------------
      go_idle();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk("R2 ready low while busy", rdy_irq, 1'b0);
      chk("R12 wp low in memory mode", wp_io16, 1'b0);
      acc_wr(0, 0, 1'b0, 1'b1, 11'd5, 16'h00AA);
      acc_rd("R2 busy read undriven", 0, 0, 1'b0, 1'b1, 11'd5, 16'h0000, 1'b0, 0, 1'b0);
      repeat (70) @(negedge clk);
      #1;
      chk("R2 ready high after init", rdy_irq, 1'b1);
      acc_rd("R2 busy write dropped", 0, 0, 1'b0, 1'b1, 11'd5, 16'h0000, 1'b1, 0, 1'b0);

      acc_wr(0, 0, 1'b0, 1'b1, 11'd4, 16'h0011);
      acc_wr(0, 0, 1'b0, 1'b1, 11'd5, 16'h0022);
      acc_rd("R3 word even", 0, 0, 1'b0, 1'b0, 11'd4, 16'h2211, 1'b1, 1, 1'b0);
      acc_rd("R3 word a0 ignored", 0, 0, 1'b0, 1'b0, 11'd5, 16'h2211, 1'b1, 0, 1'b0);
      acc_rd("R3 odd lane only", 0, 0, 1'b1, 1'b0, 11'd4, 16'h2200, 1'b1, 0, 1'b0);
      acc_rd("R3 odd byte low lane", 0, 0, 1'b0, 1'b1, 11'd5, 16'h0022, 1'b1, 0, 1'b0);
      acc_rd("R3 no enable undriven", 0, 0, 1'b1, 1'b1, 11'd4, 16'h0000, 1'b0, 0, 1'b0);
      acc_wr(0, 0, 1'b1, 1'b0, 11'd6, 16'h7700);
      acc_rd("R3 odd lane write", 0, 0, 1'b0, 1'b0, 11'd6, 16'h7700, 1'b1, 0, 1'b0);

      acc_wr(0, 1, 1'b0, 1'b1, 11'd2, 16'h005A);
      acc_rd("R4 attr word hi zero", 0, 1, 1'b0, 1'b0, 11'd2, 16'h005A, 1'b1, 0, 1'b0);
      acc_wr(0, 1, 1'b0, 1'b1, 11'd3, 16'h0077);
      acc_rd("R4 attr odd byte", 0, 1, 1'b0, 1'b1, 11'd3, 16'h0000, 1'b1, 0, 1'b0);
      acc_rd("R4 attr odd lane", 0, 1, 1'b1, 1'b0, 11'd2, 16'h0000, 1'b1, 0, 1'b0);
      acc_wr(0, 1, 1'b0, 1'b0, 11'd6, 16'h1234);
      acc_rd("R4 attr word write", 0, 1, 1'b0, 1'b0, 11'd6, 16'h0034, 1'b1, 0, 1'b0);

      acc_wr(1, 0, 1'b0, 1'b1, 11'd1, 16'h0099);
      acc_rd("R6 iord ignored", 1, 0, 1'b0, 1'b1, 11'd1, 16'h0000, 1'b0, 0, 1'b0);

      // ---------------- enter I/O personality ----------------
      acc_wr(0, 1, 1'b0, 1'b1, 11'h200, 16'h0001);
      settle();
      chk("R8 io irq idle high", rdy_irq, 1'b1);
      @(negedge clk);
      media_irq = 1'b1;
      settle();
      chk("R8 io irq active low", rdy_irq, 1'b0);
      @(negedge clk);
      media_irq = 1'b0;
      acc_rd("R6 iowr was ignored", 1, 0, 1'b0, 1'b1, 11'd1, 16'h0000, 1'b1, 0, 1'b0);
      acc_wr(1, 0, 1'b0, 1'b0, 11'd0, 16'hCAFE);
      acc_wr(1, 0, 1'b0, 1'b1, 11'd3, 16'h003C);
      acc_rd("R7 io word pair", 1, 0, 1'b0, 1'b0, 11'd2, 16'h3C00, 1'b1, 1, 1'b0);
      acc_rd("R7 io data word", 1, 0, 1'b0, 1'b0, 11'd0, 16'hCAFE, 1'b1, 1, 1'b0);
      acc_rd("R7 io data byte", 1, 0, 1'b0, 1'b1, 11'd0, 16'h00FE, 1'b1, 1, 1'b1);
      acc_rd("R7 io high addr ignored", 1, 0, 1'b0, 1'b1, 11'h0F3, 16'h003C, 1'b1, 0, 1'b0);

      // ---------------- back to memory personality ----------------
      acc_wr(0, 1, 1'b0, 1'b1, 11'h200, 16'h0000);
      @(negedge clk);
      media_irq = 1'b1;
      settle();
      chk("R5 memory ready again", rdy_irq, 1'b1);
      acc_rd("R5 iord ignored again", 1, 0, 1'b0, 1'b1, 11'd3, 16'h0000, 1'b0, 0, 1'b0);
      @(negedge clk);
      media_irq = 1'b0;

      // ---------------- disk-style personality ----------------
      rst_n   = 1'b0;
      idle_oe = 1'b0;
      noise   = 1'b1;
      go_idle();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (70) @(negedge clk);
      acc_wr(1, 0, 1'b0, 1'b1, 11'd3, 16'h0047);
      acc_rd("R9 high addr we reg ignored", 1, 0, 1'b0, 1'b1, 11'h7FB, 16'h0047, 1'b1, 1, 1'b1);
      acc_wr(1, 0, 1'b0, 1'b1, 11'd0, 16'h55AA);
      acc_rd("R11 data word", 1, 0, 1'b0, 1'b1, 11'd0, 16'h55AA, 1'b1, 1, 1'b0);
      acc_wr(1, 0, 1'b0, 1'b1, 11'd7, 16'h0050);
      acc_rd("R10 alt status", 1, 0, 1'b1, 1'b0, 11'd6, 16'h0050, 1'b1, 0, 1'b0);
      @(negedge clk);
      media_irq = 1'b1;
      settle();
      chk("R8 disk irq active high", rdy_irq, 1'b1);
      acc_wr(1, 0, 1'b1, 1'b0, 11'd6, 16'h0002);
      settle();
      chk("R10 irq disabled", rdy_irq, 1'b0);
      @(negedge clk);
      media_irq = 1'b0;
      idle_oe = 1'b1;
      go_idle();
      acc_rd("R1 mode held after oe high", 1, 0, 1'b0, 1'b1, 11'd3, 16'h0047, 1'b1, 0, 1'b0);

      repeat (2) @(negedge clk);
      report();
   end

endmodule